// File: doc/BRIEF.md
# Core Sleep Clock Gate Controller

This block decides, cycle by cycle, whether each core of a small cluster gets its clock. Core 0 is the primary core. Every other core is a coprocessor. A core that executes a wait-for-interrupt or a wait-for-event instruction asks for its clock to stop. The request is honoured only while the low-power hold bit is clear. Even then, the clock stops only once the core reports that its current instruction has completed. Any enabled interrupt aimed at a sleeping core brings its clock back.

The primary core runs from reset. A coprocessor's clock stays off after reset until the primary core's software sets that coprocessor's enable. The gate is modelled as a registered enable per core, which a downstream gating cell consumes. The bus-side clocks are not touched by this block, so other bus masters keep transferring while a core sleeps.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the outputs after that edge are: `core_clk_en[0]` = 1, every other `core_clk_en` bit = 0, and any half-taken sleep request is dropped. After reset is released, an instruction-done indication alone does not stop any clock.
- R2: A coprocessor (index i >= 1) whose clock is off since reset turns on in the cycle after `sw_clk_en[i]` is sampled high. `sw_clk_en[0]` has no effect on any output.
- R3: A wait-for-interrupt request on a running core is ignored while `lpm_hold` is 1. The clock stays on, and no request remains pending once `lpm_hold` is cleared.
- R4: With `lpm_hold` = 0, an accepted request keeps the clock on until `insn_done` for that core is sampled high. `core_clk_en` falls in the cycle after that sample. This includes the case where `insn_done` is high in the same cycle as the request.
- R5: A wait-for-event request puts a core to sleep under the same conditions and timing as a wait-for-interrupt request.
- R6: When `irq_pending[i]` is sampled high while core i is asleep, `core_clk_en[i]` is high in the next cycle.
- R7: An interrupt sampled together with a sleep request, or together with `insn_done` while a request is pending, wins. The clock never goes off, and the request is discarded.
- R8: `core_asleep[i]` is always the inverse of `core_clk_en[i]`.
- R9: Each core's sleep entry and wake depend only on that core's own request, done and interrupt inputs.
- R10: An interrupt aimed at a coprocessor whose clock has never been enabled by software does not turn its clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpm_hold | input | 1 | When 1, sleep requests are ignored |
| wfi_req | input | NUM_CORES | Per-core wait-for-interrupt request |
| wfe_req | input | NUM_CORES | Per-core wait-for-event request |
| insn_done | input | NUM_CORES | Per-core: instruction in progress completes this cycle |
| irq_pending | input | NUM_CORES | Per-core enabled interrupt present |
| sw_clk_en | input | NUM_CORES | Software enable pulse for coprocessor clocks; bit 0 unused |
| core_clk_en | output | NUM_CORES | Registered per-core clock enable |
| core_asleep | output | NUM_CORES | Per-core sleep status, high while the enable is off |

## Verification
Every internal state maps onto the registered enable within one cycle, so a wrong state transition shows at `core_clk_en` on the very next sampled cycle. The exception is a request wrongly left pending or wrongly dropped. That mistake is invisible until the next `insn_done` or interrupt, so the bench follows each such case with a done-only cycle that exposes it. Tie-break errors between an interrupt and sleep entry appear as a one-cycle dip of the enable. The bench compares every cycle, so such a dip cannot slip between samples.

// File: rtl/sck_pkg.sv
// Package: shared state encoding for the sleep clock gate controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sck_pkg;

    // Per-core gate states.
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,  // clock off, waiting for software enable
        ST_RUN   = 2'd1,  // clock running, no request
        ST_PEND  = 2'd2,  // request accepted, waiting for instruction to finish
        ST_SLEEP = 2'd3   // clock stopped until an interrupt arrives
    } core_st_t;

endpackage

// File: rtl/sck_req_qual.sv
// Module: sck_req_qual
// Merges the two sleep instruction requests of one core and masks them
// with the low-power hold bit. Purely combinational.
// Assumes the request inputs are synchronous to clk.
module sck_req_qual (
    input  logic wfi,
    input  logic wfe,
    input  logic lpm_hold,
    output logic sleep_req
);

    // Either instruction counts; the hold bit blocks both.
    always_comb begin
        sleep_req = (wfi | wfe) & ~lpm_hold;
    end

endmodule

// File: rtl/sck_core_fsm.sv
// Module: sck_core_fsm
// Gate state machine for one core. It produces a registered clock enable
// and the matching sleep status. RESET_ON selects whether the core runs from
// reset (primary core) or waits for a software enable (coprocessor).
// Assumes sleep_req is already qualified by the low-power hold bit.
module sck_core_fsm
    import sck_pkg::*;
#(
    parameter bit RESET_ON = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic insn_done,
    input  logic wake_irq,
    input  logic sw_enable,
    output logic clk_en,
    output logic asleep
);

    localparam core_st_t RST_STATE = RESET_ON ? ST_RUN : ST_OFF;

    core_st_t state_q, state_d;
    logic     clk_en_q;

    // Next-state selection; an interrupt always beats sleep entry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sw_enable) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (sleep_req && !wake_irq) begin
                    state_d = insn_done ? ST_SLEEP : ST_PEND;
                end
            end
            ST_PEND: begin
                if (wake_irq)       state_d = ST_RUN;
                else if (insn_done) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_irq) state_d = ST_RUN;
            end
            default: state_d = RST_STATE;
        endcase
    end

    // State and enable registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RST_STATE;
            clk_en_q <= RESET_ON;
        end else begin
            state_q  <= state_d;
            clk_en_q <= (state_d == ST_RUN) || (state_d == ST_PEND);
        end
    end

    // Drive the outputs from the registered enable.
    always_comb begin
        clk_en = clk_en_q;
        asleep = ~clk_en_q;
    end

    // R1: reset forces the per-core default and drops pending requests.
    p_reset_default_r1: assert property (@(posedge clk)
        !rst_n |=> (clk_en == RESET_ON) && (state_q != ST_PEND));

    // R2 / R10: a core off since reset stays off without a software enable.
    p_off_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !sw_enable) |=> !clk_en);

    // R4: a running clock cannot stop unless the instruction completed.
    p_wait_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !insn_done) |=> clk_en);

    // R6 / R7: an interrupt to any enabled core keeps or restores its clock.
    p_irq_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && wake_irq) |=> clk_en);

    // R6: a sleeping core stays asleep without an interrupt.
    p_sleep_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !wake_irq) |=> !clk_en);

endmodule

// File: rtl/sleep_clk_ctrl.sv
// Module: sleep_clk_ctrl (top)
// Sleep clock gate controller for NUM_CORES cores. Core 0 is the primary
// core and runs from reset; all others are coprocessors enabled by software.
// Assumes all inputs are synchronous to clk and rst_n is synchronous.
module sleep_clk_ctrl #(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lpm_hold,
    input  logic [NUM_CORES-1:0] wfi_req,
    input  logic [NUM_CORES-1:0] wfe_req,
    input  logic [NUM_CORES-1:0] insn_done,
    input  logic [NUM_CORES-1:0] irq_pending,
    input  logic [NUM_CORES-1:0] sw_clk_en,
    output logic [NUM_CORES-1:0] core_clk_en,
    output logic [NUM_CORES-1:0] core_asleep
);

    localparam int PRIMARY = 0;

    logic [NUM_CORES-1:0] sleep_req;

    // One qualifier and one gate state machine per core.
    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
        sck_req_qual u_qual (
            .wfi       (wfi_req[gi]),
            .wfe       (wfe_req[gi]),
            .lpm_hold  (lpm_hold),
            .sleep_req (sleep_req[gi])
        );

        sck_core_fsm #(
            .RESET_ON (gi == PRIMARY)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .sleep_req (sleep_req[gi]),
            .insn_done (insn_done[gi]),
            .wake_irq  (irq_pending[gi]),
            .sw_enable (sw_clk_en[gi]),
            .clk_en    (core_clk_en[gi]),
            .asleep    (core_asleep[gi])
        );
    end

    // R3: with the hold bit set, a running core's enable never falls on a
    // cycle where nothing was pending before (checked via the qualifier).
    p_hold_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_hold |-> (sleep_req == '0));

endmodule

// File: tb/sim_sleep_clk_ctrl.sv
// Bench for sleep_clk_ctrl: the driver task pushes expected enables into a
// queue, and the monitor pops and compares them after every rising edge.
module sim_sleep_clk_ctrl;

    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lpm_hold = 1'b0;
    logic [N-1:0] wfi_req = '0, wfe_req = '0, insn_done = '0;
    logic [N-1:0] irq_pending = '0, sw_clk_en = '0;
    logic [N-1:0] core_clk_en, core_asleep;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [N-1:0] en;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    sleep_clk_ctrl #(.NUM_CORES(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .lpm_hold    (lpm_hold),
        .wfi_req     (wfi_req),
        .wfe_req     (wfe_req),
        .insn_done   (insn_done),
        .irq_pending (irq_pending),
        .sw_clk_en   (sw_clk_en),
        .core_clk_en (core_clk_en),
        .core_asleep (core_asleep)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Drive one cycle of inputs at the falling edge and queue the expectation.
    task automatic step(input logic rst, input logic [N-1:0] wfi,
                        input logic [N-1:0] wfe, input logic [N-1:0] done,
                        input logic [N-1:0] irq, input logic lpm,
                        input logic [N-1:0] sw, input logic [N-1:0] exp_en,
                        input string tag);
        exp_t item;
        @(negedge clk);
        rst_n       = rst;
        wfi_req     = wfi;
        wfe_req     = wfe;
        insn_done   = done;
        irq_pending = irq;
        lpm_hold    = lpm;
        sw_clk_en   = sw;
        item.en     = exp_en;
        item.tag    = tag;
        exp_q.push_back(item);
    endtask

    // Monitor: compare after each rising edge, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t item;
                item = exp_q.pop_front();
                checks++;
                if (core_clk_en !== item.en) begin
                    errors++;
                    $display("FAIL %s: core_clk_en=%b expected %b", item.tag, core_clk_en, item.en);
                end
                checks++;
                if (core_asleep !== ~item.en) begin  // R8
                    errors++;
                    $display("FAIL R8 (%s): core_asleep=%b expected %b", item.tag, core_asleep, ~item.en);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus: arguments are rst, wfi, wfe, done, irq, lpm, sw, expected enable {core1,core0}.
    initial begin
        step(0, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b01, "R1 reset");
        step(0, 2'b11, 2'b00, 2'b11, 2'b11, 0, 2'b11, 2'b01, "R1 reset ignores inputs");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b01, "R1 idle");
        step(1, 2'b00, 2'b00, 2'b00, 2'b10, 0, 2'b00, 2'b01, "R10 irq to disabled coproc");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b01, 2'b01, "R2 bit0 no effect");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b10, 2'b11, "R2 coproc enable");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b11, "R2 stays on");
        // R3: hold bit masks requests; no leftover pending afterwards.
        step(1, 2'b01, 2'b00, 2'b01, 2'b00, 1, 2'b00, 2'b11, "R3 wfi held");
        step(1, 2'b01, 2'b00, 2'b00, 2'b00, 1, 2'b00, 2'b11, "R3 wfi held no done");
        step(1, 2'b00, 2'b00, 2'b01, 2'b00, 0, 2'b00, 2'b11, "R3 nothing pending");
        // R4: wait for instruction completion.
        step(1, 2'b01, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b11, "R4 request pending");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b11, "R4 still waiting");
        step(1, 2'b00, 2'b00, 2'b01, 2'b00, 0, 2'b00, 2'b10, "R4 stop after done");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b10, "R4 stays asleep");
        step(1, 2'b00, 2'b00, 2'b00, 2'b01, 0, 2'b00, 2'b11, "R6 wake core0");
        // R5: wait-for-event with done in the same cycle.
        step(1, 2'b00, 2'b10, 2'b10, 2'b00, 0, 2'b00, 2'b01, "R5 wfe sleeps coproc");
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b01, "R5 coproc asleep");
        step(1, 2'b00, 2'b00, 2'b00, 2'b10, 0, 2'b00, 2'b11, "R6 wake coproc");
        // R7: interrupt wins over entry.
        step(1, 2'b01, 2'b00, 2'b01, 2'b01, 0, 2'b00, 2'b11, "R7 irq with request");
        step(1, 2'b00, 2'b00, 2'b01, 2'b00, 0, 2'b00, 2'b11, "R7 request discarded");
        step(1, 2'b01, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b11, "R7 pending");
        step(1, 2'b00, 2'b00, 2'b01, 2'b01, 0, 2'b00, 2'b11, "R7 irq with done");
        step(1, 2'b00, 2'b00, 2'b01, 2'b00, 0, 2'b00, 2'b11, "R7 pending cancelled");
        // R9: independent cores.
        step(1, 2'b11, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b11, "R9 both pending");
        step(1, 2'b00, 2'b00, 2'b01, 2'b00, 0, 2'b00, 2'b10, "R9 core0 only");
        step(1, 2'b00, 2'b00, 2'b10, 2'b00, 0, 2'b00, 2'b00, "R9 both asleep");
        step(1, 2'b00, 2'b00, 2'b00, 2'b01, 0, 2'b00, 2'b01, "R9 wake core0 only");
        step(1, 2'b00, 2'b00, 2'b00, 2'b10, 0, 2'b00, 2'b11, "R9 wake coproc");
        // R1: reset drops a pending request and restores defaults.
        step(1, 2'b01, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b11, "R1 pending before reset");
        step(0, 2'b00, 2'b00, 2'b00, 2'b00, 0, 2'b00, 2'b01, "R1 reset defaults");
        step(1, 2'b00, 2'b00, 2'b11, 2'b00, 0, 2'b00, 2'b01, "R1 pending cleared");
        step(1, 2'b00, 2'b00, 2'b00, 2'b10, 0, 2'b00, 2'b01, "R10 coproc off again");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule